// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the eight interrupt flags that a 16-bit timer/counter and two neighbouring timers raise towards the interrupt controller. Four flags belong to the local timer: input capture, compare channel A, compare channel B and overflow. Four more are set by event strobes from other timers. The block does not count. It watches the counter value, the two compare values, a capture strobe and overflow strobes, and it turns them into sticky flags.

Software reads the flags through a byte-wide read port. It clears a flag by writing a one to that bit, or the interrupt controller clears it with a per-flag acknowledge pulse when it takes the vector. Each interrupt request is the flag gated by the matching bit of a mask input. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the flags stay cleared for two clock edges after `rst_n` rises.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset every flag reads 0 and every interrupt request is 0.
- R2: The flag layout, from bit 7 down to bit 0, is: other-timer compare (`ext_evt[3]`), other-timer overflow (`ext_evt[2]`), input capture, compare A, compare B, overflow, second other-timer compare (`ext_evt[1]`), second other-timer overflow (`ext_evt[0]`). A high bit of `ext_evt` sets its flag on the next clock edge.
- R3: When the counter equals a compare value on an edge where `tick_en` is high, that channel's flag (bit 4 for A, bit 3 for B) sets on the next edge where `tick_en` is high. It never sets on the matching tick itself.
- R4: A force strobe (`force_a` or `force_b`) never sets a compare flag. A match seen on the same tick as that channel's force strobe does not set the flag either.
- R5: With `cap_is_top` low, a `cap_evt` pulse sets bit 5 on the next edge.
- R6: With `cap_is_top` high, `cap_evt` is ignored. Bit 5 sets on an edge where `tick_en` is high and the counter equals `cap_top`.
- R7: In `wave_mode` 0 (normal) and 1 (clear on compare), `wrap_evt` sets bit 2 on the next edge and `mode_ovf_evt` is ignored.
- R8: In `wave_mode` 2 and 3, `mode_ovf_evt` sets bit 2 and `wrap_evt` is ignored.
- R9: A write with `wr_en` high clears every flag whose `wr_data` bit is 1. Bits written as 0 keep their value.
- R10: A high `ack` bit clears the matching flag on the next edge.
- R11: If a flag's set event and its clear (write-one or ack) arrive in the same cycle, the flag ends up set.
- R12: `irq_req` equals the flags ANDed bitwise with `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable, one per counter step |
| cnt_val | input | 16 | Current counter value |
| cmp_a_val | input | 16 | Compare value, channel A |
| cmp_b_val | input | 16 | Compare value, channel B |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| cap_evt | input | 1 | Input capture event strobe |
| cap_is_top | input | 1 | Capture register serves as counter TOP |
| cap_top | input | 16 | Capture register value used as TOP |
| wave_mode | input | 2 | Waveform mode: 0 normal, 1 clear on compare, 2 and 3 PWM |
| wrap_evt | input | 1 | Counter wrapped past its maximum |
| mode_ovf_evt | input | 1 | Overflow event supplied by the PWM modes |
| ext_evt | input | 4 | Event strobes from other timers |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data, ones clear flags |
| ack | input | 8 | Per-flag interrupt acknowledge pulses |
| irq_mask | input | 8 | Per-flag interrupt enables |
| rd_data | output | 8 | Flag read-back |
| irq_req | output | 8 | Masked interrupt requests |

## Verification
Event-driven flags, clears by write or ack, and capture-at-TOP all take effect on the first clock edge after the stimulus. The bench therefore drives each stimulus at a falling edge and reads the flags at the next falling edge. Compare flags need two timer ticks: one edge registers the match and a later edge with `tick_en` high sets the flag. The vectors check the flags after the matching tick, after an idle cycle with `tick_en` low, and after the next tick, so a flag that arrives early or late is caught. After reset is released, the bench waits out the two synchronizer edges before it makes its first check.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int EXT_W  = 4;

  localparam int B_X2_CMP = 7;
  localparam int B_X2_OVF = 6;
  localparam int B_CAP    = 5;
  localparam int B_CMP_A  = 4;
  localparam int B_CMP_B  = 3;
  localparam int B_OVF    = 2;
  localparam int B_X0_CMP = 1;
  localparam int B_X0_OVF = 0;

  typedef enum logic [1:0] {
    WM_NORMAL  = 2'd0,
    WM_CLR_CMP = 2'd1,
    WM_PWM_F   = 2'd2,
    WM_PWM_P   = 2'd3
  } wave_mode_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_cmp_track.sv
module tmr_cmp_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             force_i,
  output logic             hit_o
);
  logic match_q, match_d;

  always_comb begin
    match_d = match_q;
    if (tick_en) match_d = (cnt == ref_val) && !force_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign hit_o = tick_en && match_q;
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_i[i]) flag_d[i] = 1'b0;
      if (set_i[i]) flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic [CNT_W-1:0] cmp_b_val,
  input  logic             force_a,
  input  logic             force_b,
  input  logic             cap_evt,
  input  logic             cap_is_top,
  input  logic [CNT_W-1:0] cap_top,
  input  logic [1:0]       wave_mode,
  input  logic             wrap_evt,
  input  logic             mode_ovf_evt,
  input  logic [EXT_W-1:0] ext_evt,
  input  logic             wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] ack,
  input  logic [FLAG_W-1:0] irq_mask,
  output logic [FLAG_W-1:0] rd_data,
  output logic [FLAG_W-1:0] irq_req
);
  localparam int NCH = 2;

  logic              rst_sync_n;
  logic [CNT_W-1:0]  ch_ref [NCH];
  logic [NCH-1:0]    ch_force;
  logic [NCH-1:0]    ch_hit;
  logic [FLAG_W-1:0] set_vec, clr_vec, flags;
  logic              cap_set, ovf_set;
  wave_mode_e        mode;

  tmr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ch_ref[0]   = cmp_a_val;
  assign ch_ref[1]   = cmp_b_val;
  assign ch_force[0] = force_a;
  assign ch_force[1] = force_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_cmp_track #(.CNT_W(CNT_W)) i_cmp (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick_en (tick_en),
      .cnt     (cnt_val),
      .ref_val (ch_ref[c]),
      .force_i (ch_force[c]),
      .hit_o   (ch_hit[c])
    );
  end

  always_comb begin
    mode = wave_mode_e'(wave_mode);
    if (cap_is_top) cap_set = tick_en && (cnt_val == cap_top);
    else            cap_set = cap_evt;
    case (mode)
      WM_NORMAL, WM_CLR_CMP: ovf_set = wrap_evt;
      default:               ovf_set = mode_ovf_evt;
    endcase
  end

  always_comb begin
    set_vec           = '0;
    set_vec[B_X2_CMP] = ext_evt[3];
    set_vec[B_X2_OVF] = ext_evt[2];
    set_vec[B_CAP]    = cap_set;
    set_vec[B_CMP_A]  = ch_hit[0];
    set_vec[B_CMP_B]  = ch_hit[1];
    set_vec[B_OVF]    = ovf_set;
    set_vec[B_X0_CMP] = ext_evt[1];
    set_vec[B_X0_OVF] = ext_evt[0];
    clr_vec           = ack | (wr_en ? wr_data : '0);
  end

  tmr_flag_bank #(.W(FLAG_W)) i_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  assign rd_data = flags;
  assign irq_req = flags & irq_mask;
endmodule

// File: rtl/tmr_flag_chk.sv
module tmr_flag_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       tick_en,
  input logic [1:0] wave_mode,
  input logic       wrap_evt,
  input logic [3:0] ext_evt,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ack,
  input logic [7:0] irq_mask,
  input logic [7:0] rd_data,
  input logic [7:0] irq_req
);
  AST_EXT_SETS: assert property (@(posedge clk) disable iff (!rst_q)
    (ext_evt != 4'h0) |=> ((rd_data[7:6] & $past(ext_evt[3:2])) == $past(ext_evt[3:2]))); // R2

  AST_CMP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(rd_data[4]) || $rose(rd_data[3])) |-> $past(tick_en)); // R3

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_q)
    (wrap_evt && wave_mode[1] == 1'b0) |=> rd_data[2]); // R7

  AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_q)
    (ack == 8'h00 && (!wr_en || wr_data == 8'h00)) |=> (($past(rd_data) & ~rd_data) == 8'h00)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_q)
    (ack == 8'hFF && !tick_en && wrap_evt == 1'b0 && ext_evt == 4'h0 && wave_mode[1] == 1'b0)
      |=> ((rd_data & 8'b1100_0111) == 8'h00)); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_q)
    ((irq_req & ~irq_mask) == 8'h00) && ((irq_req ^ (rd_data & irq_mask)) == 8'h00)); // R12
endmodule

bind tmr_irq_flags tmr_flag_chk i_chk (
  .clk       (clk),
  .rst_q     (rst_sync_n),
  .tick_en   (tick_en),
  .wave_mode (wave_mode),
  .wrap_evt  (wrap_evt),
  .ext_evt   (ext_evt),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ack       (ack),
  .irq_mask  (irq_mask),
  .rd_data   (rd_data),
  .irq_req   (irq_req)
);

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic [15:0] cnt_val, cmp_a_val, cmp_b_val, cap_top;
  logic        force_a, force_b, cap_evt, cap_is_top;
  logic [1:0]  wave_mode;
  logic        wrap_evt, mode_ovf_evt;
  logic [3:0]  ext_evt;
  logic        wr_en;
  logic [7:0]  wr_data, ack, irq_mask, rd_data, irq_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_val(cnt_val),
    .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val), .force_a(force_a),
    .force_b(force_b), .cap_evt(cap_evt), .cap_is_top(cap_is_top),
    .cap_top(cap_top), .wave_mode(wave_mode), .wrap_evt(wrap_evt),
    .mode_ovf_evt(mode_ovf_evt), .ext_evt(ext_evt), .wr_en(wr_en),
    .wr_data(wr_data), .ack(ack), .irq_mask(irq_mask),
    .rd_data(rd_data), .irq_req(irq_req)
  );

  typedef struct packed {
    logic        tick;
    logic [15:0] cnt;
    logic        cap;
    logic        wrap;
    logic [3:0]  ext;
    logic        frc;
    logic        wr;
    logic [7:0]  wdat;
    logic [7:0]  ackv;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0005, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // R3 idle
    '{1'b1, 16'h0010, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // R3 match A, not yet
    '{1'b0, 16'h0011, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // R3 no tick
    '{1'b1, 16'h0011, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10}, // R3 A set
    '{1'b1, 16'h0020, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h10}, // R3 match B
    '{1'b1, 16'h0021, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h18}, // R3 B set
    '{1'b0, 16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h38}, // R5 capture
    '{1'b0, 16'h0000, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h3C}, // R7 wrap
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF}, // R2 ext
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h10, 8'h00, 8'hEF}, // R9 w1c
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00, 8'h00, 8'hEF}, // R9 zero keeps
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h20, 8'hCF}, // R10 ack
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'h1, 1'b0, 1'b0, 8'h00, 8'h03, 8'hCD}, // R11 set wins
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00}, // R9 clear all
    '{1'b1, 16'h0010, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00}, // R4 force at match
    '{1'b1, 16'h0011, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // R4 blocked
    '{1'b0, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00}  // R4 lone force
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tick_en = 0; cnt_val = 0; force_a = 0; force_b = 0; cap_evt = 0;
    wrap_evt = 0; mode_ovf_evt = 0; ext_evt = 0; wr_en = 0; wr_data = 0; ack = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    cmp_a_val = 16'h0010; cmp_b_val = 16'h0020; cap_top = 16'h0040;
    cap_is_top = 0; wave_mode = 2'd0; irq_mask = 8'hFF;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check8("R1 flags", rd_data, 8'h00);
    check8("R1 irq", irq_req, 8'h00);

    for (int v = 0; v < NV; v++) begin
      tick_en = VEC[v].tick; cnt_val = VEC[v].cnt; cap_evt = VEC[v].cap;
      wrap_evt = VEC[v].wrap; ext_evt = VEC[v].ext; force_a = VEC[v].frc;
      wr_en = VEC[v].wr; wr_data = VEC[v].wdat; ack = VEC[v].ackv;
      step();
      check8($sformatf("vec %0d", v), rd_data, VEC[v].exp);
      check8($sformatf("R12 vec %0d", v), irq_req, VEC[v].exp);
    end
    idle_inputs();

    // R4: force on channel B at its match
    tick_en = 1; cnt_val = 16'h0020; force_b = 1; step();
    force_b = 0; cnt_val = 16'h0021; step();
    check8("R4 force B", rd_data, 8'h00);
    idle_inputs();

    // R12: masking
    ext_evt = 4'hF; step(); idle_inputs();
    irq_mask = 8'h81; #1;
    check8("R12 mask", irq_req, 8'h81);
    irq_mask = 8'hFF;
    wr_en = 1; wr_data = 8'hFF; step(); idle_inputs();

    // R6: capture register as TOP
    cap_is_top = 1; cap_evt = 1; tick_en = 1; cnt_val = 16'h0005; step();
    check8("R6 cap_evt ignored", rd_data, 8'h00);
    cap_evt = 0; cnt_val = 16'h0040; step();
    check8("R6 top reached", rd_data, 8'h20);
    idle_inputs(); cap_is_top = 0;
    wr_en = 1; wr_data = 8'hFF; step(); idle_inputs();

    // R8: PWM mode overflow source
    wave_mode = 2'd2; wrap_evt = 1; step();
    check8("R8 wrap ignored", rd_data, 8'h00);
    wrap_evt = 0; mode_ovf_evt = 1; step();
    check8("R8 mode event", rd_data, 8'h04);
    idle_inputs(); wave_mode = 2'd1;
    wr_en = 1; wr_data = 8'hFF; step(); idle_inputs();

    // R7: mode event ignored in clear-on-compare mode
    mode_ovf_evt = 1; step();
    check8("R7 mode event ignored", rd_data, 8'h00);
    idle_inputs();

    // R11: write-one and set in same cycle
    wrap_evt = 1; step(); idle_inputs();
    wrap_evt = 1; wr_en = 1; wr_data = 8'h04; step();
    check8("R11 set beats w1c", rd_data, 8'h04);
    idle_inputs();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule